// File: doc/BRIEF.md
# Software Watchdog Timer with Prescaler

This block catches a program that has stopped running its normal loop. A fixed prescaler divides the system clock by 2048. Each prescaler wrap steps a programmable 16-bit down counter by one. Software must feed the watchdog before the counter runs out. A write of any single value is not enough: software has to write a two-word key sequence to the service register. If the counter runs out, the block sends a one-clock request to the chip's reset generator, or a one-clock non-maskable interrupt request to the interrupt controller, whichever the configuration selects.

Software sets the reload value and the action while the watchdog is stopped, and then sets the enable bit. While the watchdog runs, the reload value and the action are locked. The enable bit stays writable. At 125 MHz the period runs from about 16 us with a reload of 1 to about 1 s with a reload of 65535.

Top module: `soft_watchdog`

## Requirements
- R1: After reset the watchdog is disabled, both request outputs are low, the action is non-maskable interrupt and the reload value is 16'hFFFF.
- R2: Register map, selected by `wr_addr` when `wr_en` is high: 0 is control (bit 0 enables counting, bit 1 selects the action: 1 for reset, 0 for interrupt), 1 is the reload value, 2 is the service register. A write to address 3 has no effect.
- R3: Take the clock edge that samples the enabling write, and a reload value R of 1 or more. The first expiry occurs exactly 2048*R clock edges after that edge. The counter then reloads, so the next expiries follow every 2048*R edges.
- R4: A reload value of 0 behaves like a reload value of 1.
- R5: While disabled, the block raises no request, and the counter and prescaler stay at their starting point. Re-enabling starts a full new period.
- R6: Writing 16'h556C and then 16'hAA39 to the service register reloads the counter and clears the prescaler. The next expiry then falls 2048*R edges after the edge that sampled the 16'hAA39 write.
- R7: Between the two keys, any other value written to the service register cancels the sequence. A lone 16'hAA39 does nothing. Writes to other addresses between the two keys do not break the sequence.
- R8: On expiry exactly one of the two outputs pulses high for one clock: `wdt_rst_req_o` when the action bit is 1, and `wdt_nmi_req_o` when it is 0. The two outputs are never high together.
- R9: While the watchdog is enabled, writes to the reload value and to the action bit are ignored. The enable bit can still be written, so software can stop the watchdog.
- R10: When a completed service and a counter expiry fall on the same edge, the service wins: no request is raised and a full new period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| wdt_rst_req_o | output | 1 | One-clock reset request on expiry |
| wdt_nmi_req_o | output | 1 | One-clock non-maskable interrupt request on expiry |

## Verification
The hardest case to reach from the ports is R10, where the final service key lands on the same edge as the prescaler wrap that would expire the counter. The bench counts clock edges from the edge that sampled the enabling write. It issues the arming key one edge early, so that the closing key is sampled on exactly edge 2048 for a reload of 1. It then confirms that the expected pulse is missing and that the next pulse arrives one full period later. The locked-register and broken-sequence cases are checked the same way: any write that should have no effect must leave the expiry edge unchanged.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] REG_CTRL    = 2'd0;
    localparam logic [ADDR_W-1:0] REG_RELOAD  = 2'd1;
    localparam logic [ADDR_W-1:0] REG_SERVICE = 2'd2;

    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_ACT_BIT = 1;

    localparam logic [DATA_W-1:0] KEY_ARM  = 16'h556C;
    localparam logic [DATA_W-1:0] KEY_FIRE = 16'hAA39;

    typedef enum logic {
        ACT_NMI   = 1'b0,
        ACT_RESET = 1'b1
    } wdt_action_e;

    typedef enum logic {
        SVC_IDLE  = 1'b0,
        SVC_ARMED = 1'b1
    } svc_state_e;

    typedef struct packed {
        logic        enable;
        wdt_action_e action;
    } wdt_ctrl_t;

    function automatic logic is_write_to(input logic en, input logic [ADDR_W-1:0] addr,
                                         input logic [ADDR_W-1:0] target);
        return en && (addr == target);
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned RESET_RELOAD = 65535
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wdt_ctrl_t         ctrl,
    output logic [CNT_W-1:0]  reload
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '{enable: 1'b0, action: ACT_NMI};
            reload <= CNT_W'(RESET_RELOAD);
        end else begin
            if (is_write_to(wr_en, wr_addr, REG_CTRL)) begin
                ctrl.enable <= wr_data[CTRL_EN_BIT];
                if (!ctrl.enable) begin
                    ctrl.action <= wdt_action_e'(wr_data[CTRL_ACT_BIT]);
                end
            end
            if (is_write_to(wr_en, wr_addr, REG_RELOAD) && !ctrl.enable) begin
                reload <= wr_data[CNT_W-1:0];
            end
        end
    end

    // R9: configuration frozen while the watchdog runs
    a_r9_reload_locked: assert property (@(posedge clk) disable iff (rst)
        $past(ctrl.enable) |-> $stable(reload));

    a_r9_action_locked: assert property (@(posedge clk) disable iff (rst)
        $past(ctrl.enable) |-> $stable(ctrl.action));

endmodule

// File: rtl/wdt_service.sv
module wdt_service
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              svc_hit
);

    svc_state_e state_q, state_d;
    logic       svc_wr;

    assign svc_wr  = is_write_to(wr_en, wr_addr, REG_SERVICE);
    assign svc_hit = svc_wr && (state_q == SVC_ARMED) && (wr_data == KEY_FIRE);

    always_comb begin
        state_d = state_q;
        if (svc_wr) begin
            if (wr_data == KEY_ARM) begin
                state_d = SVC_ARMED;
            end else begin
                state_d = SVC_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SVC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // R7: a completed service leaves the checker waiting for a fresh first key
    a_r7_rearm_needed: assert property (@(posedge clk) disable iff (rst)
        svc_hit |=> (state_q == SVC_IDLE));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned PRESC_DIV = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  wdt_action_e      action,
    input  logic [CNT_W-1:0] reload,
    input  logic             svc_hit,
    output logic             rst_req,
    output logic             nmi_req
);

    localparam int unsigned PW   = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
    localparam bit          POW2 = ((PRESC_DIV & (PRESC_DIV - 1)) == 0);

    logic [PW-1:0]    presc_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] eff_reload;
    logic             tick;

    assign eff_reload = (reload == '0) ? CNT_W'(1) : reload;

    generate
        if (POW2) begin : g_pow2_tick
            assign tick = &presc_q;
        end else begin : g_cmp_tick
            assign tick = (presc_q == PW'(PRESC_DIV - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= '0;
            count_q <= '0;
            rst_req <= 1'b0;
            nmi_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            nmi_req <= 1'b0;
            if (!enable || svc_hit) begin
                presc_q <= '0;
                count_q <= eff_reload;
            end else begin
                presc_q <= tick ? '0 : presc_q + PW'(1);
                if (tick) begin
                    if (count_q <= CNT_W'(1)) begin
                        count_q <= eff_reload;
                        if (action == ACT_RESET) begin
                            rst_req <= 1'b1;
                        end else begin
                            nmi_req <= 1'b1;
                        end
                    end else begin
                        count_q <= count_q - CNT_W'(1);
                    end
                end
            end
        end
    end

    // R8: one action per expiry, one cycle wide
    a_r8_one_action: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rst_req, nmi_req}));

    a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (rst_req || nmi_req) |=> !(rst_req || nmi_req));

    // R3: counter restarts from the reload value on expiry
    a_r3_restart: assert property (@(posedge clk) disable iff (rst)
        (rst_req || nmi_req) |-> (count_q == eff_reload) && (presc_q == '0));

    // R6: a completed service restarts the period
    a_r6_service_restart: assert property (@(posedge clk) disable iff (rst)
        svc_hit |=> (count_q == $past(eff_reload)) && (presc_q == '0));

    // R5: no request while disabled
    a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !(rst_req || nmi_req));

    // R10: a service on the expiry edge suppresses the request
    a_r10_service_wins: assert property (@(posedge clk) disable iff (rst)
        svc_hit |=> !(rst_req || nmi_req));

endmodule

// File: rtl/soft_watchdog.sv
module soft_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned PRESC_DIV    = 2048,
    parameter int unsigned RESET_RELOAD = 65535
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wdt_rst_req_o,
    output logic              wdt_nmi_req_o
);

    wdt_ctrl_t        ctrl;
    logic [CNT_W-1:0] reload;
    logic             svc_hit;

    wdt_regs #(
        .CNT_W        (CNT_W),
        .RESET_RELOAD (RESET_RELOAD)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .reload  (reload)
    );

    wdt_service u_service (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .svc_hit (svc_hit)
    );

    wdt_counter #(
        .CNT_W     (CNT_W),
        .PRESC_DIV (PRESC_DIV)
    ) u_counter (
        .clk     (clk),
        .rst     (rst),
        .enable  (ctrl.enable),
        .action  (ctrl.action),
        .reload  (reload),
        .svc_hit (svc_hit),
        .rst_req (wdt_rst_req_o),
        .nmi_req (wdt_nmi_req_o)
    );

endmodule

// File: tb/soft_watchdog_tb_top.sv
module soft_watchdog_tb_top;

    localparam int PER = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        wdt_rst_req_o;
    logic        wdt_nmi_req_o;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int n_nmi = 0, n_rst = 0;
    int first_nmi = -1, second_nmi = -1, first_rst = -1;
    bit done = 0;

    soft_watchdog dut_i (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .wdt_rst_req_o (wdt_rst_req_o),
        .wdt_nmi_req_o (wdt_nmi_req_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (wdt_nmi_req_o) begin
                if (n_nmi == 0) first_nmi = cyc;
                if (n_nmi == 1) second_nmi = cyc;
                n_nmi++;
            end
            if (wdt_rst_req_o) begin
                if (n_rst == 0) first_rst = cyc;
                n_rst++;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        n_nmi = 0; n_rst = 0;
        first_nmi = -1; second_nmi = -1; first_rst = -1;
    endtask

    // called at a negedge; returns at the next negedge
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic stop_wdt();
        wr(2'd0, 16'h0000);
        repeat (3) @(negedge clk);
        clr();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic t_reset_state();
        int t0;
        chk("R1 rst_req after reset", int'(wdt_rst_req_o), 0);
        chk("R1 nmi_req after reset", int'(wdt_nmi_req_o), 0);
        repeat (100) @(negedge clk);
        chk("R1 no pulse while disabled", n_nmi + n_rst, 0);
        wr(2'd1, 16'd1);
        t0 = cyc;
        wr(2'd0, 16'h0001);          // enable only; action left at reset default
        wait_until(t0 + 1 + PER + 3);
        chk("R1 default action is NMI", n_nmi, 1);
        chk("R1 no reset pulse by default", n_rst, 0);
        stop_wdt();
    endtask

    task automatic t_nmi_timing();
        int t0;
        wr(2'd1, 16'd2);
        t0 = cyc;
        wr(2'd0, 16'h0001);
        wait_until(t0 + 1 + 4 * PER + 3);
        chk("R3 first expiry edge", first_nmi, t0 + 1 + 2 * PER);
        chk("R3 second expiry edge", second_nmi, t0 + 1 + 4 * PER);
        chk("R8 one-cycle NMI pulses", n_nmi, 2);
        chk("R8 no reset in NMI mode", n_rst, 0);
        stop_wdt();
    endtask

    task automatic t_reset_mode();
        int t0;
        wr(2'd1, 16'd1);
        t0 = cyc;
        wr(2'd0, 16'h0003);
        wait_until(t0 + 1 + PER + 3);
        chk("R8 R2 reset request edge", first_rst, t0 + 1 + PER);
        chk("R8 single reset pulse", n_rst, 1);
        chk("R8 no NMI in reset mode", n_nmi, 0);
        stop_wdt();
    endtask

    task automatic t_reload_zero();
        int t0;
        wr(2'd1, 16'd0);
        t0 = cyc;
        wr(2'd0, 16'h0001);
        wait_until(t0 + 1 + PER + 3);
        chk("R4 reload 0 acts as 1", first_nmi, t0 + 1 + PER);
        chk("R4 single pulse", n_nmi, 1);
        stop_wdt();
    endtask

    task automatic t_service();
        int t0, ts;
        wr(2'd1, 16'd2);
        t0 = cyc;
        wr(2'd0, 16'h0001);
        wait_until(t0 + 3000);
        wr(2'd2, 16'h556C);
        ts = cyc;
        wr(2'd2, 16'hAA39);
        wait_until(ts + 1 + 2 * PER + 3);
        chk("R6 expiry moved by service", first_nmi, ts + 1 + 2 * PER);
        chk("R6 original expiry suppressed", n_nmi, 1);
        stop_wdt();
    endtask

    task automatic t_broken_sequence();
        int t0, ts;
        wr(2'd1, 16'd2);
        t0 = cyc;
        wr(2'd0, 16'h0001);
        wait_until(t0 + 1000);
        wr(2'd2, 16'h556C);
        wr(2'd2, 16'h1234);
        wr(2'd2, 16'hAA39);
        wait_until(t0 + 1500);
        wr(2'd2, 16'hAA39);
        wr(2'd3, 16'hAA39);
        wait_until(t0 + 1 + 2 * PER + 3);
        chk("R7 broken sequence leaves expiry", first_nmi, t0 + 1 + 2 * PER);
        chk("R7 exactly one pulse", n_nmi, 1);
        clr();
        wr(2'd2, 16'h556C);
        wr(2'd0, 16'h0001);
        ts = cyc;
        wr(2'd2, 16'hAA39);
        wait_until(ts + 1 + 2 * PER + 3);
        chk("R7 other-address write keeps sequence", first_nmi, ts + 1 + 2 * PER);
        chk("R7 single pulse after service", n_nmi, 1);
        stop_wdt();
    endtask

    task automatic t_locks();
        int t0;
        wr(2'd1, 16'd2);
        t0 = cyc;
        wr(2'd0, 16'h0001);
        wr(2'd1, 16'd5);
        wr(2'd0, 16'h0003);
        wait_until(t0 + 1 + 2 * PER + 3);
        chk("R9 reload write ignored while on", first_nmi, t0 + 1 + 2 * PER);
        chk("R9 action write ignored while on", n_rst, 0);
        wr(2'd0, 16'h0000);
        clr();
        repeat (5000) @(negedge clk);
        chk("R9 R5 disable honoured, no pulses", n_nmi + n_rst, 0);
        clr();
    endtask

    task automatic t_restart();
        int t0, t1;
        wr(2'd1, 16'd1);
        t0 = cyc;
        wr(2'd0, 16'h0001);
        wait_until(t0 + 1500);
        wr(2'd0, 16'h0000);
        repeat (10) @(negedge clk);
        t1 = cyc;
        wr(2'd0, 16'h0001);
        wait_until(t1 + 1 + PER + 3);
        chk("R5 re-enable starts full period", first_nmi, t1 + 1 + PER);
        chk("R5 single pulse after restart", n_nmi, 1);
        stop_wdt();
    endtask

    task automatic t_collision();
        int t0;
        wr(2'd1, 16'd1);
        t0 = cyc;
        wr(2'd0, 16'h0001);
        wait_until(t0 + PER - 1);
        wr(2'd2, 16'h556C);
        wr(2'd2, 16'hAA39);          // sampled on the expiry edge t0+1+PER
        wait_until(t0 + PER + 1 + PER + 3);
        chk("R10 service beats expiry", n_nmi, 1);
        chk("R10 next expiry one period later", first_nmi, t0 + PER + 1 + PER);
        stop_wdt();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_nmi_timing();
        t_reset_mode();
        t_reload_zero();
        t_service();
        t_broken_sequence();
        t_locks();
        t_restart();
        t_collision();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule